// File: doc/BRIEF.md
# Round-Robin Central Bus Arbiter

This block is the central arbiter on a shared parallel bus with up to four initiators. Each initiator has its own request and grant line, both active low. The block also samples the shared cycle-frame and initiator-ready strobes so that it can tell when the bus is idle. It passes ownership between requesters in a rotating order, so no initiator can starve the others. When nobody is requesting, it leaves the grant parked on a fixed default agent.

The grant only moves in ways the bus protocol allows:
- On an idle bus, the old grant can drop and the new one rise at the same edge.
- On a busy bus, one clock with no grant at all is placed between the two owners, so two initiators never drive the shared address/data and parity lines at once.

An owner may keep its request asserted but leave the bus idle and never start a transfer. If it does so for sixteen clocks while another agent is waiting, the grant is taken back and passed on.

Top module: `pci_arbiter`

## Requirements
- R1: Request and grant lines are active low, one bit per agent, bit i belonging to agent i. No more than one grant bit is low in any clock.
- R2: While reset is asserted, all grant lines are high. They stay high through the first clock edge after reset is released.
- R3: When no agent is requesting, the grant settles on the default agent (agent 0). This happens at the second edge after reset, and at the edge after a no-grant gap.
- R4: When a new owner is chosen, it is the first requesting agent in increasing index order, wrapping around, starting after the last agent that won while requesting. The winner therefore drops to lowest priority.
- R5: An owner that keeps its request asserted keeps its grant. The only exception is the idle reclaim of R8.
- R6: The bus is idle when both cycle-frame and initiator-ready are high. When an edge samples an idle bus and the grant moves, the old grant rises and the new grant falls at that same edge, with no gap.
- R7: When an edge samples a busy bus and the grant must move, all grants go high for exactly one clock. The new owner is granted at the following edge.
- R8: Another agent may be requesting while the owner still requests and the bus is idle. If the owner holds the grant over sixteen consecutive edges that sample an idle bus, the grant moves at the sixteenth of those edges.
- R9: Any edge that samples a busy bus restarts the sixteen-edge idle count of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_AGENTS | Per-agent request, active low |
| frame_n | input | 1 | Shared cycle-frame strobe, active low |
| irdy_n | input | 1 | Shared initiator-ready strobe, active low |
| gnt_n | output | NUM_AGENTS | Per-agent grant, active low |

## Verification
The assertions check on every cycle that:
- at most one grant is asserted;
- no agent's grant follows another's directly while the bus is busy;
- the grant stays blank in the clock after reset;
- the grant parks when nobody requests;
- a requesting owner keeps its grant before the idle limit.

Only the bench's scenarios can show that the rotation picks the right next agent, that reclaim fires on exactly the sixteenth idle edge, and that a busy edge restarts that count. The bench shows these with directed sequences and with a long randomized run compared against a cycle model.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic grantLoad;   // install picked winner as owner
    logic grantDrop;   // blank every grant for one clock
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
`timescale 1ns/1ps
module arb_datapath #(
  parameter int NUM_AGENTS = 4,
  parameter int PARK_AGENT = 0,
  parameter int IDLE_LIMIT = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_AGENTS-1:0]         req_n,
  input  logic                          frame_n,
  input  logic                          irdy_n,
  input  arb_pkg::arbStrobe_t           stb,
  output logic                          curValid,
  output logic [$clog2(NUM_AGENTS)-1:0] curIdx,
  output logic [$clog2(NUM_AGENTS)-1:0] winIdx,
  output logic                          ownerReq,
  output logic                          otherReq,
  output logic                          busIdle,
  output logic                          idleHit,
  output logic [NUM_AGENTS-1:0]         gnt_n
);
  localparam int IDX_W = $clog2(NUM_AGENTS);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_LIMIT - 1);

  logic [NUM_AGENTS-1:0] reqVec;
  logic [NUM_AGENTS-1:0] gntVec;
  logic [IDX_W-1:0]      lastWin;
  logic [IDX_W-1:0]      ptr;
  logic [IDX_W-1:0]      cand;
  logic                  found;
  logic [CNT_W-1:0]      idleCnt;

  assign reqVec   = ~req_n;
  assign busIdle  = frame_n & irdy_n;
  assign ownerReq = curValid & reqVec[curIdx];
  assign gntVec   = curValid ? (NUM_AGENTS'(1) << curIdx) : '0;
  assign otherReq = curValid & (|(reqVec & ~gntVec));
  assign idleHit  = busIdle & (idleCnt == CNT_TOP);
  assign gnt_n    = ~gntVec;

  // rotation starts just after the agent holding lowest priority
  assign ptr = ownerReq ? curIdx : lastWin;

  always_comb begin
    winIdx = IDX_W'(PARK_AGENT);
    found  = 1'b0;
    cand   = '0;
    for (int k = 1; k <= NUM_AGENTS; k++) begin
      cand = IDX_W'((int'(ptr) + k) % NUM_AGENTS);
      if (!found && reqVec[cand]) begin
        winIdx = cand;
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curValid <= 1'b0;
      curIdx   <= IDX_W'(PARK_AGENT);
      lastWin  <= IDX_W'(PARK_AGENT);
      idleCnt  <= '0;
    end else if (stb.grantLoad) begin
      curValid <= 1'b1;
      curIdx   <= winIdx;
      if (reqVec[winIdx]) lastWin <= winIdx;
      idleCnt  <= '0;
    end else if (stb.grantDrop) begin
      curValid <= 1'b0;
      idleCnt  <= '0;
    end else begin
      if (ownerReq) lastWin <= curIdx;
      if (!busIdle)               idleCnt <= '0;
      else if (idleCnt != CNT_TOP) idleCnt <= idleCnt + 1'b1;
    end
  end

  // R1: at most one grant driven at the pins
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R7: busy bus never sees a direct owner-to-owner handover
  a_r7_busy_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!busIdle && gntVec != '0) |=> (gntVec == '0 || gntVec == $past(gntVec)));
endmodule

// File: rtl/arb_ctrl.sv
`timescale 1ns/1ps
module arb_ctrl #(
  parameter int NUM_AGENTS = 4,
  parameter int PARK_AGENT = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_AGENTS-1:0]         req_n,
  input  logic                          curValid,
  input  logic [$clog2(NUM_AGENTS)-1:0] curIdx,
  input  logic [$clog2(NUM_AGENTS)-1:0] winIdx,
  input  logic                          ownerReq,
  input  logic                          otherReq,
  input  logic                          busIdle,
  input  logic                          idleHit,
  output arb_pkg::arbStrobe_t           stb
);
  localparam int IDX_W = $clog2(NUM_AGENTS);

  logic started;
  logic wantMove;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assign wantMove = (!ownerReq && winIdx != curIdx) || (ownerReq && idleHit && otherReq);

  always_comb begin
    stb = '0;
    if (started) begin
      if (!curValid)     stb.grantLoad = 1'b1;
      else if (wantMove) begin
        if (busIdle) stb.grantLoad = 1'b1;
        else         stb.grantDrop = 1'b1;
      end
    end
  end

  // R2: one blank clock after reset release
  a_r2_blank_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> !curValid);

  // R3: from a blank grant with no requests, park on the default agent
  a_r3_park: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !curValid && (&req_n)) |=> (curValid && curIdx == IDX_W'(PARK_AGENT)));

  // R5: requesting owner keeps the grant short of the idle limit
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (curValid && ownerReq && !idleHit) |=> (curValid && curIdx == $past(curIdx)));
endmodule

// File: rtl/pci_arbiter.sv
`timescale 1ns/1ps
module pci_arbiter #(
  parameter int NUM_AGENTS = 4,
  parameter int PARK_AGENT = 0,
  parameter int IDLE_LIMIT = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_AGENTS-1:0] req_n,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  output logic [NUM_AGENTS-1:0] gnt_n
);
  localparam int IDX_W = $clog2(NUM_AGENTS);

  arb_pkg::arbStrobe_t stb;
  logic             curValid, ownerReq, otherReq, busIdle, idleHit;
  logic [IDX_W-1:0] curIdx, winIdx;

  arb_datapath #(.NUM_AGENTS(NUM_AGENTS), .PARK_AGENT(PARK_AGENT), .IDLE_LIMIT(IDLE_LIMIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .stb(stb), .curValid(curValid), .curIdx(curIdx), .winIdx(winIdx),
    .ownerReq(ownerReq), .otherReq(otherReq), .busIdle(busIdle), .idleHit(idleHit),
    .gnt_n(gnt_n)
  );

  arb_ctrl #(.NUM_AGENTS(NUM_AGENTS), .PARK_AGENT(PARK_AGENT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .curValid(curValid), .curIdx(curIdx),
    .winIdx(winIdx), .ownerReq(ownerReq), .otherReq(otherReq), .busIdle(busIdle),
    .idleHit(idleHit), .stb(stb)
  );
endmodule

// File: tb/tb_pci_arbiter.sv
`timescale 1ns/1ps
module tb_pci_arbiter;
  localparam int N = 4;
  localparam int LIM = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         frame_n, irdy_n;
  logic [N-1:0] gnt_n;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // cycle model state
  bit     mStarted, mValid;
  int     mIdx, mLast, mIdle;

  always #2 clk = ~clk;

  pci_arbiter #(.NUM_AGENTS(N), .PARK_AGENT(0), .IDLE_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n)
  );

  function automatic int pick(int ptr, logic [N-1:0] rq);
    for (int k = 1; k <= N; k++) if (rq[(ptr + k) % N]) return (ptr + k) % N;
    return 0;
  endfunction

  function automatic logic [N-1:0] expGnt();
    logic [N-1:0] v = '1;
    if (mValid) v[mIdx] = 1'b0;
    return v;
  endfunction

  task automatic modelStep();
    logic [N-1:0] rq = ~req_n;
    bit idle = frame_n & irdy_n;
    bit own, oth, mv;
    int w;
    if (!rst_n) begin
      mStarted = 0; mValid = 0; mIdx = 0; mLast = 0; mIdle = 0;
    end else if (!mStarted) begin
      mStarted = 1;
    end else begin
      own = mValid && rq[mIdx];
      w   = pick(own ? mIdx : mLast, rq);
      oth = 0;
      for (int i = 0; i < N; i++) if (rq[i] && i != mIdx) oth = 1;
      if (!mValid) begin
        mValid = 1; mIdx = w; if (rq[w]) mLast = w; mIdle = 0;
      end else begin
        mv = (!own && w != mIdx) || (own && idle && mIdle == LIM - 1 && oth);
        if (mv) begin
          if (idle) begin mIdx = w; if (rq[w]) mLast = w; end
          else mValid = 0;
          mIdle = 0;
        end else begin
          if (own) mLast = mIdx;
          if (!idle) mIdle = 0;
          else if (mIdle < LIM - 1) mIdle++;
        end
      end
    end
  endtask

  task automatic chk(logic [N-1:0] act, logic [N-1:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: gnt_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one edge: update model, then compare away from the edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    chk(gnt_n, expGnt(), "R4 R5 R6 R7 R8 model");
    nChecks++;
    if ($countones(~gnt_n) > 1) begin
      nFail++;
      $display("FAIL R1: gnt_n actual=%b expected at most one low", gnt_n);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; req_n = '1; frame_n = 1; irdy_n = 1;
    tick(); tick();
    chk(gnt_n, 4'b1111, "R2 during reset");
    rst_n = 1;
    tick(); chk(gnt_n, 4'b1111, "R2 blank clock");
    tick(); chk(gnt_n, 4'b1110, "R3 park after reset");

    req_n = 4'b1011;                       // agent 2 requests, idle bus
    tick(); chk(gnt_n, 4'b1011, "R6 direct idle handover");

    frame_n = 0; irdy_n = 0; req_n = 4'b0001;   // agents 1,2,3, busy
    for (int i = 0; i < 3; i++) begin tick(); chk(gnt_n, 4'b1011, "R5 owner holds"); end

    req_n = 4'b0101;                       // owner 2 drops on busy bus
    tick(); chk(gnt_n, 4'b1111, "R7 gap clock");
    tick(); chk(gnt_n, 4'b0111, "R4 rotation after 2 gives 3");

    frame_n = 1; irdy_n = 1; req_n = 4'b1101;   // only agent 1
    tick(); chk(gnt_n, 4'b1101, "R4 R6 wrap to 1 without gap");

    req_n = 4'b0101;                       // 1 holds, 3 waits, idle
    for (int i = 0; i < LIM - 1; i++) begin tick(); chk(gnt_n, 4'b1101, "R8 before limit"); end
    tick(); chk(gnt_n, 4'b0111, "R8 reclaim at sixteenth idle edge");

    req_n = 4'b0110;                       // 0 and 3, owner 3
    for (int i = 0; i < 10; i++) tick();
    frame_n = 0;
    tick(); chk(gnt_n, 4'b0111, "R9 busy edge holds");
    frame_n = 1;
    for (int i = 0; i < LIM - 1; i++) begin tick(); chk(gnt_n, 4'b0111, "R9 count restarted"); end
    tick(); chk(gnt_n, 4'b1110, "R8 R9 reclaim after restart");

    req_n = 4'b1011;
    tick(); chk(gnt_n, 4'b1011, "R6 idle handover to 2");
    req_n = 4'b1111; frame_n = 0;
    tick(); chk(gnt_n, 4'b1111, "R7 gap before park");
    tick(); chk(gnt_n, 4'b1110, "R3 park after gap");
    frame_n = 1;

    for (int c = 0; c < 4000; c++) begin
      bit quiet = ((c / 200) % 2) == 1;
      if (quiet) begin
        frame_n = 1; irdy_n = 1;
        if ($urandom_range(31) == 0) req_n[$urandom_range(N - 1)] ^= 1'b1;
      end else begin
        if ($urandom_range(3) == 0) req_n[$urandom_range(N - 1)] ^= 1'b1;
        if ($urandom_range(7) == 0) frame_n = ~frame_n;
        if ($urandom_range(4) == 0) irdy_n = ~irdy_n;
      end
      if (c == 2500) begin rst_n = 0; tick(); rst_n = 1; end
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule